// File: doc/BRIEF.md
# Slow clock period meter

This block measures the frequency of a slow, unknown clock against the fast reference clock that runs all of its logic. Software picks one of up to four slow inputs, programs a window length counted in slow-clock periods, and sets an enable bit. The block then waits for a rising edge of the chosen slow clock, counts fast-clock cycles until the programmed number of further slow rising edges has passed, and freezes the result. Dividing the fast count by the window length gives the slow period in fast cycles.

The selected slow input is resynchronised into the fast domain, and each rising edge seen there counts as one slow period. Two pending flags report the outcome: one marks a finished measurement, and the other marks a fast counter that ran out of range, which tells software to program a shorter window. Each flag has its own interrupt enable, and a single interrupt line combines them. Flags are cleared by writing ones. All registers sit on a simple synchronous word-addressed port: a write occurs on the clock edge at which the write strobe is high, and read data reflects the current address combinationally.

Top module: `slowclk_meter`

## Requirements
- R1: After reset the control (0x00), window (0x04), status (0x08), fast result (0x0C), slow progress (0x10) and source (0x20) registers read 0, the interrupt-enable register (0x14) reads 3, and the interrupt output is low.
- R2: Only bit 0 of the control register is stored. Writing all ones to 0x00 reads back as 1.
- R3: The 2-bit field at 0x20 picks the slow input by index. With a window of N periods (12-bit value at 0x04), the result at 0x0C equals N times the selected input's period in fast cycles.
- R4: Writing 1 to control bit 0 while it holds 0 clears both counters and both flags, and the measurement starts at the next slow rising edge. A restart after an overflow ends with only the done flag set.
- R5: When N slow rising edges follow the start edge, status bit 0 (done) sets, the fast result stops changing, and 0x10 reads N.
- R6: If the fast counter would pass its all-ones value, it stays at all-ones, status bit 1 (overflow) sets, counting stops, and done stays clear.
- R7: A window of 0 finishes as soon as the measurement is enabled, with done set and a fast result of 0.
- R8: The interrupt output is high when done is set and bit 0 of 0x14 is 1, or when overflow is set and bit 1 of 0x14 is 1. These enables have no effect on the status bits.
- R9: Writing 1 to bit 0 or bit 1 of 0x18 clears done or overflow respectively. Zero bits leave the flags unchanged.
- R10: Writing 0 to control bit 0 during a measurement stops it, and done does not set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk_i | input | NSRC (4) | Candidate slow clocks |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Masked OR of the pending flags |

## Verification
The overflow outcome is the hardest case to reach from the ports. With the default 24-bit fast counter, a window would need about sixteen million reference cycles. The bench therefore builds the block with a 10-bit fast counter and selects its slowest generated input with a long window. This drives the counter into saturation within a few thousand cycles, and a near-limit window checks the boundary just below it. The bench generates the slow inputs as exact multiples of the reference period, so every expected fast count is known exactly.

// File: rtl/slowclk_meter_pkg.sv
package slowclk_meter_pkg;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 32;

   localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
   localparam logic [ADDR_W-1:0] OFS_WIN  = 8'h04;
   localparam logic [ADDR_W-1:0] OFS_STAT = 8'h08;
   localparam logic [ADDR_W-1:0] OFS_FAST = 8'h0C;
   localparam logic [ADDR_W-1:0] OFS_PROG = 8'h10;
   localparam logic [ADDR_W-1:0] OFS_IEN  = 8'h14;
   localparam logic [ADDR_W-1:0] OFS_ICLR = 8'h18;
   localparam logic [ADDR_W-1:0] OFS_SRC  = 8'h20;

   typedef enum logic [1:0] {
      MS_IDLE  = 2'd0,
      MS_ARMED = 2'd1,
      MS_RUN   = 2'd2
   } meas_state_e;
endpackage

// File: rtl/slowclk_edge.sv
module slowclk_edge #(
   parameter int NSRC        = 4,
   parameter int SEL_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  src_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             rise_o
);
   logic                   picked;
   logic [SYNC_STAGES-1:0] chain_q;
   logic                   last_q;

   generate
      if (NSRC == 1) begin : g_single
         logic unused_sel;
         assign unused_sel = ^sel_i;
         assign picked = src_i[0];
      end else begin : g_mux
         always_comb begin
            picked = 1'b0;
            for (int i = 0; i < NSRC; i++) begin
               if (sel_i == SEL_W'(i)) picked = src_i[i];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[SYNC_STAGES-2:0], picked};
         last_q  <= chain_q[SYNC_STAGES-1];
      end
   end

   assign rise_o = chain_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/slowclk_core.sv
module slowclk_core
   import slowclk_meter_pkg::*;
#(
   parameter int FAST_W = 24,
   parameter int SLOW_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              en_i,
   input  logic [SLOW_W-1:0] lim_i,
   input  logic              rise_i,
   input  logic              clr_done_i,
   input  logic              clr_over_i,
   output logic [FAST_W-1:0] fast_o,
   output logic [SLOW_W-1:0] slow_o,
   output logic              done_o,
   output logic              over_o
);
   localparam logic [FAST_W-1:0] FAST_MAX = '1;

   meas_state_e       st_q;
   logic [FAST_W-1:0] fast_q;
   logic [SLOW_W-1:0] slow_q;
   logic [SLOW_W-1:0] slow_nx;
   logic              done_q, over_q;

   assign slow_nx = slow_q + SLOW_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= MS_IDLE;
         fast_q <= '0;
         slow_q <= '0;
         done_q <= 1'b0;
         over_q <= 1'b0;
      end else begin
         if (clr_done_i) done_q <= 1'b0;
         if (clr_over_i) over_q <= 1'b0;
         if (start_i) begin
            fast_q <= '0;
            slow_q <= '0;
            over_q <= 1'b0;
            if (lim_i == '0) begin
               done_q <= 1'b1;
               st_q   <= MS_IDLE;
            end else begin
               done_q <= 1'b0;
               st_q   <= MS_ARMED;
            end
         end else if (!en_i) begin
            st_q <= MS_IDLE;
         end else begin
            case (st_q)
               MS_ARMED: if (rise_i) st_q <= MS_RUN;
               MS_RUN: begin
                  if (fast_q == FAST_MAX) begin
                     over_q <= 1'b1;
                     st_q   <= MS_IDLE;
                  end else begin
                     fast_q <= fast_q + FAST_W'(1);
                     if (rise_i) begin
                        slow_q <= slow_nx;
                        if (slow_nx == lim_i) begin
                           done_q <= 1'b1;
                           st_q   <= MS_IDLE;
                        end
                     end
                  end
               end
               default: st_q <= MS_IDLE;
            endcase
         end
      end
   end

   assign fast_o = fast_q;
   assign slow_o = slow_q;
   assign done_o = done_q;
   assign over_o = over_q;
endmodule

// File: rtl/slowclk_regs.sv
module slowclk_regs
   import slowclk_meter_pkg::*;
#(
   parameter int FAST_W = 24,
   parameter int SLOW_W = 12,
   parameter int SEL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [FAST_W-1:0] fast_i,
   input  logic [SLOW_W-1:0] slow_i,
   input  logic              done_i,
   input  logic              over_i,
   output logic              en_o,
   output logic [SLOW_W-1:0] lim_o,
   output logic [SEL_W-1:0]  sel_o,
   output logic              start_o,
   output logic              clr_done_o,
   output logic              clr_over_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_o
);
   logic              en_q;
   logic [SLOW_W-1:0] lim_q;
   logic [SEL_W-1:0]  sel_q;
   logic [1:0]        ien_q;
   logic              unused_wdata;

   assign unused_wdata = ^wdata_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         lim_q <= '0;
         sel_q <= '0;
         ien_q <= 2'b11;
      end else if (wr_en_i) begin
         case (addr_i)
            OFS_CTRL: en_q  <= wdata_i[0];
            OFS_WIN:  lim_q <= wdata_i[SLOW_W-1:0];
            OFS_IEN:  ien_q <= wdata_i[1:0];
            OFS_SRC:  sel_q <= wdata_i[SEL_W-1:0];
            default: ;
         endcase
      end
   end

   assign start_o    = wr_en_i && (addr_i == OFS_CTRL) && wdata_i[0] && !en_q;
   assign clr_done_o = wr_en_i && (addr_i == OFS_ICLR) && wdata_i[0];
   assign clr_over_o = wr_en_i && (addr_i == OFS_ICLR) && wdata_i[1];

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         OFS_CTRL: rdata_o = DATA_W'(en_q);
         OFS_WIN:  rdata_o = DATA_W'(lim_q);
         OFS_STAT: rdata_o = DATA_W'({over_i, done_i});
         OFS_FAST: rdata_o = DATA_W'(fast_i);
         OFS_PROG: rdata_o = DATA_W'(slow_i);
         OFS_IEN:  rdata_o = DATA_W'(ien_q);
         OFS_SRC:  rdata_o = DATA_W'(sel_q);
         default:  rdata_o = '0;
      endcase
   end

   assign irq_o = |({over_i, done_i} & ien_q);
   assign en_o  = en_q;
   assign lim_o = lim_q;
   assign sel_o = sel_q;
endmodule

// File: rtl/slowclk_meter.sv
module slowclk_meter
   import slowclk_meter_pkg::*;
#(
   parameter int NSRC        = 4,
   parameter int FAST_W      = 24,
   parameter int SLOW_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   slow_clk_i,
   input  logic              wr_en_i,
   input  logic [7:0]        addr_i,
   input  logic [31:0]       wdata_i,
   output logic [31:0]       rdata_o,
   output logic              irq_o
);
   localparam int SEL_W = 2;

   generate
      if (NSRC < 1 || NSRC > (1 << SEL_W)) begin : g_bad_nsrc
         $error("NSRC must be between 1 and 4");
      end
      if (FAST_W < 2 || FAST_W > DATA_W) begin : g_bad_fast
         $error("FAST_W must be between 2 and 32");
      end
      if (SLOW_W < 1 || SLOW_W > DATA_W) begin : g_bad_slow
         $error("SLOW_W must be between 1 and 32");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              en_q, start, clr_done, clr_over, rise;
   logic [SLOW_W-1:0] lim;
   logic [SEL_W-1:0]  sel;
   logic [FAST_W-1:0] fast_q;
   logic [SLOW_W-1:0] slow_q;
   logic              done_q, over_q;

   slowclk_edge #(
      .NSRC(NSRC), .SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)
   ) u_edge (
      .clk(clk), .rst_n(rst_n), .src_i(slow_clk_i), .sel_i(sel), .rise_o(rise)
   );

   slowclk_core #(.FAST_W(FAST_W), .SLOW_W(SLOW_W)) u_core (
      .clk(clk), .rst_n(rst_n), .start_i(start), .en_i(en_q), .lim_i(lim),
      .rise_i(rise), .clr_done_i(clr_done), .clr_over_i(clr_over),
      .fast_o(fast_q), .slow_o(slow_q), .done_o(done_q), .over_o(over_q)
   );

   slowclk_regs #(.FAST_W(FAST_W), .SLOW_W(SLOW_W), .SEL_W(SEL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .fast_i(fast_q), .slow_i(slow_q), .done_i(done_q),
      .over_i(over_q), .en_o(en_q), .lim_o(lim), .sel_o(sel), .start_o(start),
      .clr_done_o(clr_done), .clr_over_o(clr_over), .rdata_o(rdata_o),
      .irq_o(irq_o)
   );
endmodule

// File: rtl/slowclk_meter_chk.sv
module slowclk_meter_chk #(
   parameter int FAST_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic              done,
   input logic              over,
   input logic [FAST_W-1:0] fast,
   input logic              irq
);
   // R6
   done_over_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && over));

   // R6
   over_saturated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      over |-> (fast == {FAST_W{1'b1}}));

   // R5
   result_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(done)) |-> $stable(fast));

   // R8
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (done || over));

   // R10
   no_done_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && $past(!en)) |-> !$rose(done));
endmodule

bind slowclk_meter slowclk_meter_chk #(.FAST_W(FAST_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en_q), .done(done_q), .over(over_q),
   .fast(fast_q), .irq(irq_o)
);

// File: tb/slowclk_meter_bench.sv
`timescale 1ns/1ps
module slowclk_meter_bench;
   localparam int FW = 10;
   localparam logic [31:0] FMAX = 32'h3FF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  slow = 4'b0000;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   int          n_vec = 0;
   int          n_bad = 0;
   bit          ended = 1'b0;

   always #4 clk = ~clk;

   // Sources 0..2 have periods 10, 14, 22 fast cycles; source 3 is held low.
   int ph0 = 0, ph1 = 0, ph2 = 0;
   always @(negedge clk) begin
      ph0 = ph0 + 1; if (ph0 == 5)  begin ph0 = 0; slow[0] = ~slow[0]; end
      ph1 = ph1 + 1; if (ph1 == 7)  begin ph1 = 0; slow[1] = ~slow[1]; end
      ph2 = ph2 + 1; if (ph2 == 11) begin ph2 = 0; slow[2] = ~slow[2]; end
   end

   slowclk_meter #(.FAST_W(FW)) u_slowclk_meter (
      .clk(clk), .rst_n(rst_n), .slow_clk_i(slow), .wr_en_i(wr_en),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
   );

   // {source, window, expected fast count}
   localparam logic [39:0] VEC [0:6] = '{
      {4'd0, 12'd4,  24'd40},
      {4'd1, 12'd3,  24'd42},
      {4'd2, 12'd2,  24'd44},
      {4'd0, 12'd1,  24'd10},
      {4'd1, 12'd0,  24'd0},
      {4'd1, 12'd40, 24'd560},
      {4'd2, 12'd46, 24'd1012}
   };

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic run(input logic [1:0] src, input logic [11:0] win);
      logic [31:0] st;
      wr(8'h20, 32'(src));
      wr(8'h00, 32'h0);
      wr(8'h04, 32'(win));
      wr(8'h00, 32'h1);
      for (int i = 0; i < 4000; i++) begin
         rd(8'h08, st);
         if (st != 0) break;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(8'h00, v); chk("R1 ctrl", v, 0);
      rd(8'h04, v); chk("R1 window", v, 0);
      rd(8'h08, v); chk("R1 status", v, 0);
      rd(8'h0C, v); chk("R1 fast", v, 0);
      rd(8'h10, v); chk("R1 progress", v, 0);
      rd(8'h14, v); chk("R1 ien", v, 3);
      rd(8'h20, v); chk("R1 source", v, 0);
      chk("R1 irq", 32'(irq), 0);

      // R3 R5 R7 R8 vector table
      for (int k = 0; k < 7; k++) begin
         run(VEC[k][39:36], VEC[k][35:24]);
         rd(8'h0C, v); chk("R3 fast count", v, 32'(VEC[k][23:0]));
         rd(8'h08, v); chk("R5 done status", v, 1);
         rd(8'h10, v); chk("R5 progress", v, 32'(VEC[k][35:24]));
         chk("R8 irq on done", 32'(irq), 1);
         if (VEC[k][35:24] == 0) begin
            rd(8'h0C, v); chk("R7 zero window", v, 0);
         end
         repeat (30) @(negedge clk);
         rd(8'h0C, v); chk("R5 result frozen", v, 32'(VEC[k][23:0]));
         wr(8'h18, 32'h1);
      end

      // R2 only bit 0 of control
      wr(8'h04, 32'h0);
      wr(8'h00, 32'h0);
      wr(8'h00, 32'hFFFF_FFFF);
      rd(8'h00, v); chk("R2 ctrl readback", v, 1);

      // R6 overflow: 100 x 22 cycles exceeds 10-bit counter
      run(2'd2, 12'd100);
      rd(8'h08, v); chk("R6 overflow status", v, 2);
      rd(8'h0C, v); chk("R6 saturated", v, FMAX);
      chk("R8 irq on overflow", 32'(irq), 1);

      // R4 restart clears overflow
      run(2'd0, 12'd2);
      rd(8'h08, v); chk("R4 restart status", v, 1);
      rd(8'h0C, v); chk("R4 restart fast", v, 20);

      // R8 mask does not hide status; R9 write-one-to-clear
      wr(8'h14, 32'h0);
      run(2'd0, 12'd3);
      rd(8'h08, v); chk("R8 masked status", v, 1);
      chk("R8 masked irq", 32'(irq), 0);
      wr(8'h14, 32'h3);
      chk("R8 unmasked irq", 32'(irq), 1);
      wr(8'h18, 32'h0);
      rd(8'h08, v); chk("R9 zero write", v, 1);
      wr(8'h18, 32'h2);
      rd(8'h08, v); chk("R9 other bit", v, 1);
      wr(8'h18, 32'h1);
      rd(8'h08, v); chk("R9 cleared", v, 0);
      chk("R9 irq cleared", 32'(irq), 0);

      // R10 abort: stuck source, disable, then a live source
      wr(8'h20, 32'h3);
      wr(8'h00, 32'h0);
      wr(8'h04, 32'd2);
      wr(8'h00, 32'h1);
      repeat (50) @(negedge clk);
      wr(8'h00, 32'h0);
      wr(8'h20, 32'h0);
      repeat (100) @(negedge clk);
      rd(8'h08, v); chk("R10 aborted status", v, 0);
      rd(8'h10, v); chk("R10 no progress", v, 0);
      chk("R10 irq", 32'(irq), 0);

      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule